// File: doc/BRIEF.md
# Variable-Page Translation Lookup Buffer with Zone Protection

This block is a fully associative address translation buffer. A requester gives it a 32-bit virtual address, an access kind (read, write or instruction fetch) and a privilege flag (user or supervisor). The block compares the address against every stored entry at once. One clock later it reports hit, miss or protection fault. On a hit it also reports the physical page base, the page-size code and the index of the entry that decided the result.

Each entry is two 32-bit words plus an 8-bit owner tag. The tag word holds the page number, a valid flag and a per-entry size code, so pages from 1 KB to 16 MB can sit side by side. The data word holds the physical page number, write and execute enables and a 4-bit zone selector. An external 32-bit zone register gives each of 16 zones a 2-bit code. That code can hide an entry from user mode, keep the entry's own enables, or grant write and execute rights. A simple write port loads either word of any entry. A tag write also records the current process tag as the owner of the entry.

Top module: `tlbLookup`

## Requirements
- R1: Tag word layout: bits 31:10 are the page number, bit 6 is valid, bits 9:7 are a size code s giving a page of 1 KB·4^s (1 KB up to 16 MB). An entry's address test passes when the request address and the tag word agree on every bit at or above position 10+2s.
- R2: An entry whose valid bit is 0 never takes part in a lookup.
- R3: A tag write (wrEn=1, wrSel=0) stores the pid input as the entry's owner. An owner of 0 matches any pid. A nonzero owner must equal the pid at lookup time, or the entry is skipped.
- R4: Entries are tried from index 0 upward. The first entry that passes the address, owner and zone-visibility tests alone decides the result. If none passes, the status is miss (2'b01). Whenever the status is not hit, rspIdx, rspSize and rspPa are 0.
- R5: Data word layout: bit 9 is execute enable, bit 8 is write enable, bits 7:4 are zone z. The zone code is zpr bits [31-2z : 30-2z], so zone 0 uses bits 31:30. Code 1 applies the entry's own enables.
- R6: Zone code 0 makes the entry invisible to user requests (reqUser=1), and the search goes on to later entries. Supervisor requests still see the entry.
- R7: Zone code 2 grants write and execute to supervisor requests only. Zone code 3 grants them to every request.
- R8: A zone number larger than ZONE_LIMIT (default 12), or ZONES_ON=0, forces zone code 1.
- R9: Reads (reqAccess 2'b00, and 2'b11) never fault. A write (2'b01) without write permission, or a fetch (2'b10) without execute permission, on the deciding entry gives protection fault (2'b10).
- R10: On a hit, rspPa equals data-word bits 31:10, with bits 9:0 cleared, ANDed with PA_MASK (default 32'h0FFF_FFFF). rspSize is the entry's size code and rspIdx its index.
- R11: The status encoding is 2'b00 hit, 2'b01 miss, 2'b10 fault. The result of a request presented at one rising edge appears after that edge with rspValid=1. rspValid is 0 in every cycle that follows no request.
- R12: Reset clears all entries, so every lookup misses until entries are written. After reset, rspValid=0 and the status is miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one entry word this cycle |
| wrSel | input | 1 | 0 selects the tag word, 1 selects the data word |
| wrIdx | input | 6 | Entry index to write |
| wrWord | input | 32 | Word to store |
| pid | input | 8 | Current process tag |
| zpr | input | 32 | Zone code register, 2 bits per zone |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 32 | Virtual address |
| reqAccess | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| reqUser | input | 1 | 1 for a user-mode request |
| rspValid | output | 1 | Result valid |
| rspStatus | output | 2 | 00 hit, 01 miss, 10 fault |
| rspPa | output | 32 | Masked physical page base |
| rspSize | output | 3 | Size code of the deciding entry |
| rspIdx | output | 6 | Index of the deciding entry |

## Verification
The assertions assume that pid, zpr and the request fields are stable across the edge that captures a request, and that a write and a lookup to the same entry are not issued in the same cycle. The bench changes pid and zpr only between operations, and it issues writes and lookups in separate cycles. Random addresses are confined to a 64 MB window so that pages of every size collide often, and a small pid set makes owner matches and mismatches both frequent. Directed cases cover layered page sizes, invalid entries, each zone code under both privilege levels, and zone numbers on either side of ZONE_LIMIT.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef enum logic [1:0] {
    ST_HIT   = 2'b00,
    ST_MISS  = 2'b01,
    ST_FAULT = 2'b10
  } tlbStatus_e;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  // Tag word field positions
  localparam int TAG_VALID = 6;
  localparam int TAG_SZ_LO = 7;
  // Data word field positions
  localparam int DAT_WR    = 8;
  localparam int DAT_EX    = 9;
  localparam int DAT_ZN_LO = 4;

  typedef struct packed {
    logic wrTag;
    logic wrData;
    logic capture;
  } tlbStrobes_t;

  // Mask keeping the page-number bits for size code s (page = 1 KB * 4^s)
  function automatic logic [31:0] pageMask(input logic [2:0] s);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, s, 1'b0};
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  // 2-bit zone code; zone 0 lives in the top two bits
  function automatic logic [1:0] zoneField(input logic [31:0] zr, input logic [3:0] z);
    logic [4:0] sh;
    sh = 5'd30 - {z, 1'b0};
    return 2'(zr >> sh);
  endfunction
endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        reqValid,
  output tlbStrobes_t stb,
  output logic        rspValid
);
  always_comb begin
    stb.wrTag   = wrEn && !wrSel;
    stb.wrData  = wrEn && wrSel;
    stb.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int          ENTRIES    = 64,
  parameter int          ZONE_LIMIT = 12,
  parameter bit          ZONES_ON   = 1'b1,
  parameter logic [31:0] PA_MASK    = 32'h0FFF_FFFF,
  localparam int         IW         = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  tlbStrobes_t     stb,
  input  logic [IW-1:0]   wrIdx,
  input  logic [31:0]     wrWord,
  input  logic [7:0]      pid,
  input  logic [31:0]     zpr,
  input  logic [31:0]     reqVa,
  input  logic [1:0]      reqAccess,
  input  logic            reqUser,
  output tlbStatus_e      rspStatus,
  output logic [31:0]     rspPa,
  output logic [2:0]      rspSize,
  output logic [IW-1:0]   rspIdx
);
  logic [31:0] tagMem  [ENTRIES];
  logic [31:0] dataMem [ENTRIES];
  logic [7:0]  tidMem  [ENTRIES];

  logic [ENTRIES-1:0] passVec, wrOkVec, exOkVec, firstVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic [31:0] mask;
    logic [3:0]  zsel;
    logic [1:0]  zc;
    logic        addrHit, tidHit, hide, grant;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagMem[i]  <= '0;
        dataMem[i] <= '0;
        tidMem[i]  <= '0;
      end else begin
        if (stb.wrTag && wrIdx == IW'(i)) begin
          tagMem[i] <= wrWord;
          tidMem[i] <= pid;
        end
        if (stb.wrData && wrIdx == IW'(i)) dataMem[i] <= wrWord;
      end
    end

    always_comb begin
      mask    = pageMask(tagMem[i][TAG_SZ_LO +: 3]);
      addrHit = (reqVa & mask) == (tagMem[i] & mask);
      tidHit  = (tidMem[i] == 8'd0) || (tidMem[i] == pid);
      zsel    = dataMem[i][DAT_ZN_LO +: 4];
      zc      = (!ZONES_ON || int'(zsel) > ZONE_LIMIT) ? 2'd1 : zoneField(zpr, zsel);
      hide    = (zc == 2'd0) && reqUser;
      grant   = (zc == 2'd3) || (zc == 2'd2 && !reqUser);
      passVec[i] = tagMem[i][TAG_VALID] && addrHit && tidHit && !hide;
      wrOkVec[i] = dataMem[i][DAT_WR] || grant;
      exOkVec[i] = dataMem[i][DAT_EX] || grant;
    end
  end

  logic          found;
  logic [IW-1:0] pick;
  tlbStatus_e    nextStatus;

  always_comb begin
    found    = 1'b0;
    pick     = '0;
    firstVec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (passVec[i] && !found) begin
        found       = 1'b1;
        pick        = IW'(i);
        firstVec[i] = 1'b1;
      end
    end
    if (!found)                                           nextStatus = ST_MISS;
    else if (reqAccess == ACC_WRITE && !wrOkVec[pick])    nextStatus = ST_FAULT;
    else if (reqAccess == ACC_FETCH && !exOkVec[pick])    nextStatus = ST_FAULT;
    else                                                  nextStatus = ST_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspStatus <= ST_MISS;
      rspPa     <= '0;
      rspSize   <= '0;
      rspIdx    <= '0;
    end else if (stb.capture) begin
      rspStatus <= nextStatus;
      if (nextStatus == ST_HIT) begin
        rspPa   <= {dataMem[pick][31:10], 10'b0} & PA_MASK;
        rspSize <= tagMem[pick][TAG_SZ_LO +: 3];
        rspIdx  <= pick;
      end else begin
        rspPa   <= '0;
        rspSize <= '0;
        rspIdx  <= '0;
      end
    end
  end

  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstVec));
  p_nonhit_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspStatus != ST_HIT |-> (rspIdx == '0 && rspSize == '0 && rspPa == '0));
  p_read_no_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && (reqAccess == ACC_READ || reqAccess == 2'b11)) |=> rspStatus != ST_FAULT);
  p_pa_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspPa & ~PA_MASK) == 32'd0);
  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspStatus != 2'b11);
  p_no_pass_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && passVec == '0) |=> rspStatus == ST_MISS);
endmodule

// File: rtl/tlbLookup.sv
module tlbLookup
  import tlbPkg::*;
#(
  parameter int          ENTRIES    = 64,
  parameter int          ZONE_LIMIT = 12,
  parameter bit          ZONES_ON   = 1'b1,
  parameter logic [31:0] PA_MASK    = 32'h0FFF_FFFF,
  localparam int         IW         = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [IW-1:0] wrIdx,
  input  logic [31:0]   wrWord,
  input  logic [7:0]    pid,
  input  logic [31:0]   zpr,
  input  logic          reqValid,
  input  logic [31:0]   reqVa,
  input  logic [1:0]    reqAccess,
  input  logic          reqUser,
  output logic          rspValid,
  output logic [1:0]    rspStatus,
  output logic [31:0]   rspPa,
  output logic [2:0]    rspSize,
  output logic [IW-1:0] rspIdx
);
  tlbStrobes_t stb;
  tlbStatus_e  status;

  tlbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .reqValid(reqValid), .stb(stb), .rspValid(rspValid)
  );

  tlbDatapath #(
    .ENTRIES(ENTRIES), .ZONE_LIMIT(ZONE_LIMIT),
    .ZONES_ON(ZONES_ON), .PA_MASK(PA_MASK)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .wrWord(wrWord),
    .pid(pid), .zpr(zpr), .reqVa(reqVa), .reqAccess(reqAccess),
    .reqUser(reqUser), .rspStatus(status), .rspPa(rspPa),
    .rspSize(rspSize), .rspIdx(rspIdx)
  );

  assign rspStatus = status;
endmodule

// File: tb/tb_tlbLookup.sv
module tb_tlbLookup;
  localparam int          ZL = 12;
  localparam logic [31:0] PM = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [31:0] wrWord = '0;
  logic [7:0]  pid = '0;
  logic [31:0] zpr = 32'h5555_5555;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [31:0] rspPa;
  logic [2:0]  rspSize;
  logic [5:0]  rspIdx;

  tlbLookup #(.ENTRIES(64), .ZONE_LIMIT(ZL), .ZONES_ON(1'b1), .PA_MASK(PM)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrWord(wrWord), .pid(pid), .zpr(zpr), .reqValid(reqValid),
    .reqVa(reqVa), .reqAccess(reqAccess), .reqUser(reqUser),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspPa(rspPa),
    .rspSize(rspSize), .rspIdx(rspIdx)
  );

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  logic [31:0] mTag [64];
  logic [31:0] mData [64];
  logic [7:0]  mTid [64];

  function automatic void refLook(input logic [31:0] va, input logic [1:0] acc,
                                  input logic usr, output logic [1:0] st,
                                  output logic [5:0] ix, output logic [2:0] sz,
                                  output logic [31:0] pa);
    st = 2'b01; ix = '0; sz = '0; pa = '0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] m;
      logic [3:0]  z;
      logic [1:0]  zc;
      logic        g, w, x;
      if (!mTag[i][6]) continue;
      m = ~((32'd1 << (10 + 2 * int'(mTag[i][9:7]))) - 32'd1);
      if ((va & m) != (mTag[i] & m)) continue;
      if (mTid[i] != 8'd0 && mTid[i] != pid) continue;
      z  = mData[i][7:4];
      zc = (int'(z) > ZL) ? 2'd1 : 2'((zpr >> (30 - 2 * int'(z))) & 32'd3);
      if (zc == 2'd0 && usr) continue;
      g = (zc == 2'd3) || (zc == 2'd2 && !usr);
      w = mData[i][8] | g;
      x = mData[i][9] | g;
      if ((acc == 2'b01 && !w) || (acc == 2'b10 && !x)) begin
        st = 2'b10;
        return;
      end
      st = 2'b00; ix = 6'(i); sz = mTag[i][9:7];
      pa = {mData[i][31:10], 10'b0} & PM;
      return;
    end
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrEntry(input bit sel, input logic [5:0] idx, input logic [31:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = idx; wrWord = w;
    if (!sel) begin mTag[idx] = w; mTid[idx] = pid; end
    else      mData[idx] = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] va,
                      input logic [1:0] acc, input logic usr);
    logic [1:0] eSt; logic [5:0] eIx; logic [2:0] eSz; logic [31:0] ePa;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAccess = acc; reqUser = usr;
    refLook(va, acc, usr, eSt, eIx, eSz, ePa);
    @(negedge clk);
    reqValid = 1'b0;
    check(req, rspValid === 1'b1, "rspValid", 64'(rspValid), 64'd1);
    check(req, rspStatus === eSt && rspIdx === eIx && rspSize === eSz && rspPa === ePa,
          $sformatf("va=%h acc=%0d user=%0b {st,idx,sz,pa}", va, acc, usr),
          {rspStatus, rspIdx, rspSize, 8'h0, rspPa},
          {eSt, eIx, eSz, 8'h0, ePa});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mTag[i] = '0; mData[i] = '0; mTid[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", rspValid === 1'b0 && rspStatus === 2'b01, "reset {valid,status}",
          64'({rspValid, rspStatus}), 64'({1'b0, 2'b01}));
    look("R12", 32'h0001_0000, 2'b00, 1'b0);
    // R11: idle cycle gives no result
    @(negedge clk);
    check("R11", rspValid === 1'b0, "idle rspValid", 64'(rspValid), 64'd0);

    // R1/R10: 4 KB page at index 5
    wrEntry(1'b0, 6'd5, 32'h0001_0000 | (32'd1 << 7) | 32'h40);
    wrEntry(1'b1, 6'd5, 32'hF234_5000 | 32'h300);
    look("R10", 32'h0001_0ABC, 2'b00, 1'b0);
    check("R10", rspPa === 32'h0234_5000 && rspIdx === 6'd5, "pa/idx",
          {26'h0, rspIdx, rspPa}, {26'h0, 6'd5, 32'h0234_5000});
    look("R1", 32'h0001_1000, 2'b00, 1'b0);
    // R4: 1 KB page at lower index 2 overlapping the same area
    wrEntry(1'b0, 6'd2, 32'h0001_0000 | 32'h40);
    wrEntry(1'b1, 6'd2, 32'h0000_8000 | 32'h300);
    look("R4", 32'h0001_0100, 2'b00, 1'b0);
    look("R1", 32'h0001_0ABC, 2'b00, 1'b0);
    // R2: invalid entry at index 1 ignored
    wrEntry(1'b0, 6'd1, 32'h0001_0000);
    wrEntry(1'b1, 6'd1, 32'h0000_4000 | 32'h300);
    look("R2", 32'h0001_0100, 2'b01, 1'b0);
    // R3: owned entry at index 0
    pid = 8'd7;
    wrEntry(1'b0, 6'd0, 32'h0001_0000 | 32'h40);
    wrEntry(1'b1, 6'd0, 32'h0000_C000);
    look("R3", 32'h0001_0010, 2'b00, 1'b0);
    pid = 8'd3;
    look("R3", 32'h0001_0010, 2'b00, 1'b0);
    pid = 8'd7;
    // R9: entry 0 has no write/execute enable, zone 0 code 1
    look("R9", 32'h0001_0010, 2'b01, 1'b0);
    look("R9", 32'h0001_0010, 2'b10, 1'b1);
    look("R9", 32'h0001_0010, 2'b11, 1'b1);
    // R7: zone 0 code 3, then code 2
    zpr = 32'hD555_5555;
    look("R7", 32'h0001_0010, 2'b01, 1'b1);
    zpr = 32'h9555_5555;
    look("R7", 32'h0001_0010, 2'b01, 1'b1);
    look("R7", 32'h0001_0010, 2'b10, 1'b0);
    // R6: zone 0 code 0
    zpr = 32'h1555_5555;
    look("R6", 32'h0001_0010, 2'b00, 1'b1);
    look("R6", 32'h0001_0010, 2'b00, 1'b0);
    // R5: entry 0 moved to zone 5 (zpr bits 21:20)
    wrEntry(1'b1, 6'd0, 32'h0000_C000 | (32'd5 << 4));
    zpr = 32'h5575_5555;
    look("R5", 32'h0001_0010, 2'b01, 1'b0);
    zpr = 32'h5555_5555;
    look("R5", 32'h0001_0010, 2'b01, 1'b0);
    // R8: zone 13 is beyond ZONE_LIMIT, zone 12 is not
    zpr = 32'hFFFF_FFFF;
    wrEntry(1'b1, 6'd0, 32'h0000_C000 | (32'd13 << 4));
    look("R8", 32'h0001_0010, 2'b01, 1'b0);
    wrEntry(1'b1, 6'd0, 32'h0000_C000 | (32'd12 << 4));
    look("R8", 32'h0001_0010, 2'b01, 1'b0);
    // R1: 16 MB page
    wrEntry(1'b0, 6'd63, 32'h0300_0000 | (32'd7 << 7) | 32'h40);
    wrEntry(1'b1, 6'd63, 32'h0500_0000);
    look("R1", 32'h03FF_FFFC, 2'b00, 1'b1);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r < 3) begin
        logic [31:0] t;
        t = ($urandom & 32'h03FF_FC00) | (32'($urandom_range(0, 7)) << 7)
            | ((($urandom & 3) != 0) ? 32'h40 : 32'h0);
        pid = 8'($urandom_range(0, 3));
        wrEntry(1'b0, 6'($urandom), t);
      end else if (r < 6) begin
        wrEntry(1'b1, 6'($urandom), $urandom);
      end else if (r == 6) begin
        zpr = $urandom;
        pid = 8'($urandom_range(0, 3));
      end else begin
        look("R4", $urandom & 32'h03FF_FFFF, 2'($urandom), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule